// File: doc/BRIEF.md
# Camera Timing Counter-Timer Set

This block groups the timing counters that a camera acquisition channel uses. It holds a free-running period generator, two exposure pulse generators and a gated event counter. All of them advance on a one-microsecond strobe, `usec_tick`, that is supplied from outside. The period generator makes a repeating one-tick pulse, which can pace line or frame triggers. The two exposure generators are fired together by one selectable event. Each one then stays high for its own programmed number of ticks. The event counter counts line starts, frame starts or microseconds inside a selectable gate window. It exposes the running count of the current window and the total of the last window that closed.

Software configures the block through a write port, and it reads values back through a combinational read port. Every counter and register is `CNT_W` bits wide, 32 by default. A 32-bit microsecond period reaches just over 71 minutes.

Register map, with `N_EXP` = 2:
- address 0: period
- address 1: width of exposure output 0
- address 2: width of exposure output 1
- address 3: control
- address 4: running count, read only
- address 5: final count, read only

Control fields:
- bits [1:0] fire source: 0 = period pulse, 1 = `acq_trig`, 2 = rising edge of `fval`, 3 = rising edge of `lval`
- bits [5:4] event kind: 0 = `lval` rising edges, 1 = `fval` rising edges, 2 = ticks, 3 = nothing
- bits [9:8] gate kind: 0 = `lval` high, 1 = `fval` high, 2 = from one `acq_trig` to the next, 3 = `acq_active` high

Each exposure generator is a two-state machine:
- IDLE goes to PULSE on a fire event when its width is nonzero. The remaining count is loaded with the width.
- PULSE counts down once per tick. It returns to IDLE on the tick that consumes the last unit.

The event counter is a two-state machine:
- CLOSED goes to OPEN on gate start. Gate start is the gate level going high, or an `acq_trig` pulse in trigger-gate mode. The running count clears on this transition.
- OPEN goes back to CLOSED when the gate level goes low. The running count is copied to the final count on this transition.
- In trigger-gate mode, OPEN stays OPEN on each `acq_trig` pulse. The pulse copies the running count to the final count and restarts the running count.

Top module: `cam_timer_set`

## Requirements
- R1: After reset, `astable_o` and `expo_o` are low, and every readable register and count reads zero.
- R2: A write stores `wr_data` into the register at `wr_addr`, for addresses 0 to 3. The combinational read port returns that register at the same address. Address 4 returns the running count, address 5 returns the final count, and addresses 6 and 7 read zero.
- R3: With a nonzero period P, `astable_o` goes high on every P-th tick, counted from the last period write. It stays high until the next tick.
- R4: A period of zero keeps `astable_o` low. Any write to the period register drops `astable_o` and restarts the tick count.
- R5: Both exposure outputs fire on the event chosen by control bits [1:0]. After firing, an output stays high through W further ticks, where W is its own width register. A width of zero leaves that output low.
- R6: A fire event that arrives while an exposure output is high is ignored. The pulse still ends W ticks after the first fire event.
- R7: Control bits [5:4] select what the event counter counts: 0 counts `lval` rising edges, 1 counts `fval` rising edges, 2 counts ticks, and 3 counts nothing.
- R8: Control bits [9:8] select the gate: 0 is `lval` high, 1 is `fval` high, 3 is `acq_active` high. The running count clears at gate start, with an event in that same cycle counting as 1. It then counts events while the gate is open.
- R9: When a level gate closes, the final count takes the running count. While the gate stays closed, the running count holds.
- R10: With gate kind 2, each `acq_trig` pulse copies the running count to the final count and restarts the count. An event in the same cycle as the pulse counts as the first event of the new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| usec_tick | input | 1 | One-cycle strobe once per microsecond |
| fval | input | 1 | Frame valid level |
| lval | input | 1 | Line valid level |
| acq_trig | input | 1 | Acquisition trigger, one-cycle pulse |
| acq_active | input | 1 | Acquisition in progress level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | CNT_W | Read data, combinational |
| astable_o | output | 1 | Period generator pulse |
| expo_o | output | N_EXP | Exposure pulses, one bit per generator |

## Verification
Two things can land in the same clock cycle and must both take effect: a trigger-gate restart and a counted tick. The bench selects tick counting with the trigger gate and lets four ticks accumulate. It then drives `acq_trig` and `usec_tick` high together. It expects the final count to read 4 and the running count to read 1, which shows the coincident tick went into the new window rather than the old one or neither. A second overlap is a fire event arriving on the same tick that shortens an active exposure pulse. This is judged by the pulse ending exactly W ticks after the first fire event.

// File: rtl/cam_tmr_pkg.sv
package cam_tmr_pkg;

    typedef enum logic [1:0] {
        FIRE_ASTABLE = 2'd0,
        FIRE_TRIG    = 2'd1,
        FIRE_FRAME   = 2'd2,
        FIRE_LINE    = 2'd3
    } fire_sel_e;

    typedef enum logic [1:0] {
        EV_LINE  = 2'd0,
        EV_FRAME = 2'd1,
        EV_USEC  = 2'd2,
        EV_NONE  = 2'd3
    } ev_sel_e;

    typedef enum logic [1:0] {
        GT_LINE  = 2'd0,
        GT_FRAME = 2'd1,
        GT_TRIG  = 2'd2,
        GT_ACQ   = 2'd3
    } gate_sel_e;

    typedef enum logic {
        MS_IDLE  = 1'b0,
        MS_PULSE = 1'b1
    } ms_state_e;

    typedef enum logic {
        GS_CLOSED = 1'b0,
        GS_OPEN   = 1'b1
    } gate_state_e;

endpackage

// File: rtl/ct_astable.sv
module ct_astable #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         load_i,
    input  logic [W-1:0] period_i,
    output logic         pulse_o,
    output logic         fire_o
);
    logic [W-1:0] cnt;
    logic         wrap;

    assign wrap   = (period_i != '0) && (cnt >= period_i - 1'b1);
    assign fire_o = !load_i && tick_i && wrap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            pulse_o <= 1'b0;
        end else if (load_i) begin
            cnt     <= '0;
            pulse_o <= 1'b0;
        end else if (tick_i) begin
            if (period_i == '0) begin
                cnt     <= '0;
                pulse_o <= 1'b0;
            end else if (wrap) begin
                cnt     <= '0;
                pulse_o <= 1'b1;
            end else begin
                cnt     <= cnt + 1'b1;
                pulse_o <= 1'b0;
            end
        end
    end

    // R4: a zero period with no write pending leaves the output low next cycle
    assert_zero_period_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (period_i == '0 && !load_i) |=> !pulse_o);

    // R3: the pulse only changes on a tick or a period write
    assert_edge_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(pulse_o));

endmodule

// File: rtl/ct_mono.sv
module ct_mono
    import cam_tmr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         fire_i,
    input  logic [W-1:0] width_i,
    output logic         pulse_o
);
    ms_state_e    st, st_n;
    logic [W-1:0] rem, rem_n;

    always_comb begin
        st_n  = st;
        rem_n = rem;
        unique case (st)
            MS_IDLE: begin
                if (fire_i && width_i != '0) begin
                    st_n  = MS_PULSE;
                    rem_n = width_i;
                end
            end
            MS_PULSE: begin
                if (tick_i) begin
                    rem_n = rem - 1'b1;
                    if (rem == 1) st_n = MS_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= MS_IDLE;
            rem <= '0;
        end else begin
            st  <= st_n;
            rem <= rem_n;
        end
    end

    always_comb pulse_o = (st == MS_PULSE);

    // R5: an active pulse always has time left to run
    assert_rem_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == MS_PULSE) |-> (rem != '0));

    // R6: without a tick, a running pulse keeps its remainder whatever fire does
    assert_ignore_refire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == MS_PULSE && !tick_i) |=> (st == MS_PULSE && $stable(rem)));

endmodule

// File: rtl/ct_evcount.sv
module ct_evcount
    import cam_tmr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         event_i,
    input  logic         gate_i,
    input  logic         trig_mode_i,
    input  logic         restart_i,
    output logic [W-1:0] live_o,
    output logic [W-1:0] final_o
);
    gate_state_e  st, st_n;
    logic [W-1:0] live_n, final_n;
    logic [W-1:0] ev_one;

    assign ev_one = {{(W-1){1'b0}}, event_i};

    always_comb begin
        st_n    = st;
        live_n  = live_o;
        final_n = final_o;
        unique case (st)
            GS_CLOSED: begin
                if (trig_mode_i ? restart_i : gate_i) begin
                    st_n   = GS_OPEN;
                    live_n = ev_one;
                end
            end
            GS_OPEN: begin
                if (trig_mode_i) begin
                    if (restart_i) begin
                        final_n = live_o;
                        live_n  = ev_one;
                    end else begin
                        live_n = live_o + ev_one;
                    end
                end else if (!gate_i) begin
                    st_n    = GS_CLOSED;
                    final_n = live_o;
                end else begin
                    live_n = live_o + ev_one;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= GS_CLOSED;
            live_o  <= '0;
            final_o <= '0;
        end else begin
            st      <= st_n;
            live_o  <= live_n;
            final_o <= final_n;
        end
    end

    // R9: closing a level gate captures the running count
    assert_final_on_close_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == GS_OPEN && !trig_mode_i && !gate_i) |=> (final_o == $past(live_o)));

    // R9: a closed gate that stays closed holds the running count
    assert_hold_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == GS_CLOSED && !(trig_mode_i ? restart_i : gate_i)) |=> $stable(live_o));

    // R10: a trigger restart captures the old count and restarts from 0 or 1
    assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == GS_OPEN && trig_mode_i && restart_i) |=>
            (final_o == $past(live_o) && live_o <= 1));

endmodule

// File: rtl/cam_timer_set.sv
module cam_timer_set
    import cam_tmr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int N_EXP = 2,
    parameter int AW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             usec_tick,
    input  logic             fval,
    input  logic             lval,
    input  logic             acq_trig,
    input  logic             acq_active,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             astable_o,
    output logic [N_EXP-1:0] expo_o
);
    localparam int A_PERIOD = 0;
    localparam int A_CTRL   = N_EXP + 1;
    localparam int A_LIVE   = N_EXP + 2;
    localparam int A_FINAL  = N_EXP + 3;

    logic [CNT_W-1:0] period_q, ctrl_q;
    logic [CNT_W-1:0] width_q [N_EXP];
    logic [CNT_W-1:0] live_cnt, final_cnt;
    logic             fval_q, lval_q, fval_rise, lval_rise;
    logic             ast_fire, fire, ev, gate;
    fire_sel_e        fsel;
    ev_sel_e          esel;
    gate_sel_e        gsel;

    assign fsel = fire_sel_e'(ctrl_q[1:0]);
    assign esel = ev_sel_e'(ctrl_q[5:4]);
    assign gsel = gate_sel_e'(ctrl_q[9:8]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
            ctrl_q   <= '0;
            fval_q   <= 1'b0;
            lval_q   <= 1'b0;
        end else begin
            fval_q <= fval;
            lval_q <= lval;
            if (wr_en && wr_addr == AW'(A_PERIOD)) period_q <= wr_data;
            if (wr_en && wr_addr == AW'(A_CTRL))   ctrl_q   <= wr_data;
        end
    end

    assign fval_rise = fval && !fval_q;
    assign lval_rise = lval && !lval_q;

    always_comb begin
        unique case (fsel)
            FIRE_ASTABLE: fire = ast_fire;
            FIRE_TRIG:    fire = acq_trig;
            FIRE_FRAME:   fire = fval_rise;
            FIRE_LINE:    fire = lval_rise;
        endcase
        unique case (esel)
            EV_LINE:  ev = lval_rise;
            EV_FRAME: ev = fval_rise;
            EV_USEC:  ev = usec_tick;
            EV_NONE:  ev = 1'b0;
        endcase
        unique case (gsel)
            GT_LINE:  gate = lval;
            GT_FRAME: gate = fval;
            GT_TRIG:  gate = 1'b0;
            GT_ACQ:   gate = acq_active;
        endcase
    end

    ct_astable #(.W(CNT_W)) u_ast (
        .clk(clk), .rst_n(rst_n), .tick_i(usec_tick),
        .load_i(wr_en && wr_addr == AW'(A_PERIOD)),
        .period_i(period_q), .pulse_o(astable_o), .fire_o(ast_fire)
    );

    for (genvar g = 0; g < N_EXP; g++) begin : g_exp
        always_ff @(posedge clk) begin
            if (!rst_n) width_q[g] <= '0;
            else if (wr_en && wr_addr == AW'(g + 1)) width_q[g] <= wr_data;
        end
        ct_mono #(.W(CNT_W)) u_mono (
            .clk(clk), .rst_n(rst_n), .tick_i(usec_tick), .fire_i(fire),
            .width_i(width_q[g]), .pulse_o(expo_o[g])
        );
    end

    ct_evcount #(.W(CNT_W)) u_evc (
        .clk(clk), .rst_n(rst_n), .event_i(ev), .gate_i(gate),
        .trig_mode_i(gsel == GT_TRIG), .restart_i(acq_trig),
        .live_o(live_cnt), .final_o(final_cnt)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(A_PERIOD)) rd_data = period_q;
        if (rd_addr == AW'(A_CTRL))   rd_data = ctrl_q;
        if (rd_addr == AW'(A_LIVE))   rd_data = live_cnt;
        if (rd_addr == AW'(A_FINAL))  rd_data = final_cnt;
        for (int i = 0; i < N_EXP; i++)
            if (rd_addr == AW'(i + 1)) rd_data = width_q[i];
    end

endmodule

// File: tb/sim_cam_timer_set.sv
module sim_cam_timer_set;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        usec_tick = 1'b0, fval = 1'b0, lval = 1'b0;
    logic        acq_trig = 1'b0, acq_active = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        astable_o;
    logic [1:0]  expo_o;
    int          n_vec = 0, n_bad = 0;
    bit          done = 0;

    cam_timer_set u0 (
        .clk(clk), .rst_n(rst_n), .usec_tick(usec_tick), .fval(fval), .lval(lval),
        .acq_trig(acq_trig), .acq_active(acq_active), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .astable_o(astable_o), .expo_o(expo_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic test_reset();
        logic [31:0] d;
        chk("R1 astable", {31'd0, astable_o}, 0);
        chk("R1 expo", {30'd0, expo_o}, 0);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk("R1 read", d, 0);
        end
    endtask

    task automatic test_regs();
        logic [31:0] d;
        wr(0, 32'h1234_5678); wr(1, 32'hA5); wr(2, 32'h5A00); wr(3, 32'h0000_0321);
        rd(0, d); chk("R2 period", d, 32'h1234_5678);
        rd(1, d); chk("R2 width0", d, 32'hA5);
        rd(2, d); chk("R2 width1", d, 32'h5A00);
        rd(3, d); chk("R2 ctrl", d, 32'h321);
        rd(6, d); chk("R2 unused6", d, 0);
        rd(7, d); chk("R2 unused7", d, 0);
        wr(1, 0); wr(2, 0); wr(3, 0); wr(0, 0);
    endtask

    task automatic test_astable();
        wr(0, 3);
        usec_tick = 1'b1;
        for (int k = 1; k <= 9; k++) begin
            step();
            chk("R3 astable", {31'd0, astable_o}, (k % 3 == 0) ? 1 : 0);
        end
        usec_tick = 1'b0;
        wr(0, 3);
        chk("R4 write clears", {31'd0, astable_o}, 0);
        wr(0, 0);
        usec_tick = 1'b1;
        for (int k = 0; k < 8; k++) begin
            step();
            chk("R4 zero period", {31'd0, astable_o}, 0);
        end
        usec_tick = 1'b0;
    endtask

    task automatic test_mono();
        wr(1, 2); wr(2, 4); wr(3, 1);
        acq_trig = 1'b1; step(); acq_trig = 1'b0;
        chk("R5 fired", {30'd0, expo_o}, 2'b11);
        usec_tick = 1'b1;
        step(); chk("R5 tick1", {30'd0, expo_o}, 2'b11);
        step(); chk("R5 tick2", {30'd0, expo_o}, 2'b10);
        step(); chk("R5 tick3", {30'd0, expo_o}, 2'b10);
        step(); chk("R5 tick4", {30'd0, expo_o}, 2'b00);
        usec_tick = 1'b0;
        wr(1, 0);
        acq_trig = 1'b1; step(); acq_trig = 1'b0;
        chk("R5 zero width", {30'd0, expo_o}, 2'b10);
        usec_tick = 1'b1;
        for (int k = 0; k < 4; k++) step();
        usec_tick = 1'b0;
        chk("R5 zero width end", {30'd0, expo_o}, 2'b00);
        wr(1, 2); wr(3, 2);
        fval = 1'b1; step(); fval = 1'b0;
        chk("R5 fval source", {30'd0, expo_o}, 2'b11);
        usec_tick = 1'b1;
        for (int k = 0; k < 4; k++) step();
        usec_tick = 1'b0;
        chk("R5 fval source end", {30'd0, expo_o}, 2'b00);
    endtask

    task automatic test_refire();
        wr(3, 1); wr(1, 3);
        acq_trig = 1'b1; step(); acq_trig = 1'b0;
        chk("R6 start", {31'd0, expo_o[0]}, 1);
        usec_tick = 1'b1; step();
        acq_trig = 1'b1; step(); acq_trig = 1'b0;
        chk("R6 refire ignored", {31'd0, expo_o[0]}, 1);
        step();
        chk("R6 ends on time", {31'd0, expo_o[0]}, 0);
        usec_tick = 1'b0; step();
        chk("R6 stays low", {31'd0, expo_o[0]}, 0);
        usec_tick = 1'b1;
        for (int k = 0; k < 4; k++) step();
        usec_tick = 1'b0;
        wr(3, 0);
    endtask

    task automatic line_pulse();
        lval = 1'b1; step(); lval = 1'b0; step();
    endtask

    task automatic test_lines();
        logic [31:0] d;
        wr(3, 32'h100);
        fval = 1'b1; step();
        for (int k = 0; k < 3; k++) line_pulse();
        rd(4, d); chk("R8 live lines", d, 3);
        fval = 1'b0; step();
        rd(5, d); chk("R9 final", d, 3);
        line_pulse();
        rd(4, d); chk("R9 hold closed", d, 3);
        fval = 1'b1; step();
        rd(4, d); chk("R8 clear at start", d, 0);
        for (int k = 0; k < 2; k++) line_pulse();
        fval = 1'b0; step();
        rd(5, d); chk("R9 final second", d, 2);
    endtask

    task automatic frame_pulse();
        fval = 1'b1; step(); fval = 1'b0; step();
    endtask

    task automatic test_kinds();
        logic [31:0] d;
        wr(3, 32'h310);
        acq_active = 1'b1; step();
        frame_pulse(); frame_pulse();
        rd(4, d); chk("R7 frames", d, 2);
        wr(3, 32'h330);
        frame_pulse();
        rd(4, d); chk("R7 none", d, 2);
        acq_active = 1'b0; step();
        rd(5, d); chk("R8 acq gate final", d, 2);
        wr(3, 32'h320);
        acq_active = 1'b1; step();
        usec_tick = 1'b1;
        for (int k = 0; k < 5; k++) step();
        usec_tick = 1'b0;
        acq_active = 1'b0; step();
        rd(5, d); chk("R7 ticks", d, 5);
    endtask

    task automatic test_trig();
        logic [31:0] d;
        wr(3, 32'h220);
        acq_trig = 1'b1; step(); acq_trig = 1'b0;
        rd(4, d); chk("R10 opened", d, 0);
        usec_tick = 1'b1;
        for (int k = 0; k < 4; k++) step();
        rd(4, d); chk("R10 running", d, 4);
        acq_trig = 1'b1; step(); acq_trig = 1'b0;
        rd(5, d); chk("R10 final", d, 4);
        rd(4, d); chk("R10 coincident tick", d, 1);
        step(); step();
        usec_tick = 1'b0;
        rd(4, d); chk("R10 continues", d, 3);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        test_reset();
        test_regs();
        test_astable();
        test_mono();
        test_refire();
        test_lines();
        test_kinds();
        test_trig();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1;
            n_vec++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule